// File: doc/BRIEF.md
# Oscillator Clock Failure Supervisor

This block watches an external high-speed oscillator from a reference clock derived from the internal oscillator. It declares the external clock dead when no rising edge has arrived for a set number of reference cycles. It then steers the clock tree into a safe state.

Every rising edge of the monitored clock flips a toggle flop in the monitored domain. A synchroniser chain carries that toggle into the reference domain, where a change of its value marks one edge. A gap counter runs only while the supervisor is armed. It is armed when software has enabled it, the oscillator is switched on, and its startup delay has completed.

On a failure the block does four things:
- It requests that the oscillator be turned off.
- It sends a one-cycle pulse to the timer break and fault inputs.
- It raises a level interrupt flag that stays set until software clears it.
- It steers the clock tree only when the failed oscillator is on the system-clock path. If the oscillator is the system clock, or feeds the PLL while the PLL is the system clock, the block forces a switch to the internal 16 MHz oscillator. In the PLL case it also asks for the PLL to be shut down.

A separate sticky enable for the low-speed oscillator monitor sits beside the main logic. Once set, only a reset, a real-time-clock software reset or a low-speed failure can clear it.

Top module: `osc_fail_supervisor`

## Requirements
- R1: After a synchronous reset, every output is low (the request pulses, break, forced switch, interrupt flag and low-speed monitor enable).
- R2: While armed, no failure is reported as long as monitored-clock rising edges keep arriving, with gaps of fewer than MISS_LIMIT reference cycles.
- R3: While armed, a failure is reported once no monitored edge has been seen for MISS_LIMIT consecutive reference cycles. Seen from the ports, the request appears no sooner than MISS_LIMIT cycles and no later than MISS_LIMIT+6 cycles after the clock stops.
- R4: The supervisor is armed only when mon_en, osc_on and osc_ready are all high. Otherwise a stopped clock causes no failure.
- R5: A failure produces osc_off_req and tmr_break together, each high for exactly one reference cycle.
- R6: sysclk_src encodes the system-clock source: 2'b00 other, 2'b01 internal 16 MHz, 2'b10 external oscillator, 2'b11 PLL. force_int16 pulses with the failure only when sysclk_src is 2'b10, or when it is 2'b11 with pll_src_ext high.
- R7: pll_off_req pulses with the failure only when sysclk_src is 2'b11 and pll_src_ext is high.
- R8: irq_flag is set by a failure and stays high until a cycle with irq_clr high.
- R9: After a failure, no further failure is reported until osc_on has been low for at least one cycle. After that the block re-arms.
- R10: lse_mon_active is set by lse_mon_set and stays set. It is cleared only by rst, rtc_sw_rst or lse_fail, and a clear wins over a set in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock from the internal oscillator |
| rst | input | 1 | Synchronous active-high reset |
| mon_clk | input | 1 | Monitored external oscillator clock |
| mon_en | input | 1 | Software enable of the supervisor |
| osc_on | input | 1 | Monitored oscillator is switched on |
| osc_ready | input | 1 | Oscillator startup delay has completed |
| sysclk_src | input | 2 | Current system-clock source code |
| pll_src_ext | input | 1 | PLL input is the monitored oscillator |
| irq_clr | input | 1 | Software clear of the interrupt flag |
| lse_mon_set | input | 1 | Software set of the low-speed monitor enable |
| rtc_sw_rst | input | 1 | Real-time-clock software reset |
| lse_fail | input | 1 | Low-speed oscillator failure detected |
| osc_off_req | output | 1 | One-cycle request to turn the oscillator off |
| pll_off_req | output | 1 | One-cycle request to turn the PLL off |
| force_int16 | output | 1 | One-cycle request to switch system clock to the internal 16 MHz oscillator |
| tmr_break | output | 1 | One-cycle pulse to timer break and fault inputs |
| irq_flag | output | 1 | Sticky interrupt flag, routed to the non-maskable interrupt |
| lse_mon_active | output | 1 | Sticky low-speed monitor enable |

## Verification
The bench builds the block with MISS_LIMIT = 6 and SYNC_STAGES = 2, and runs the monitored clock at 14 ns against a 5 ns reference. Edge gaps of about three reference cycles then sit safely under the limit, and a stopped clock trips the detector within a dozen cycles. This small limit makes the detection window of R3 visible cycle by cycle. It also lets every source-code and PLL-input combination be walked quickly, followed by the re-arm, gating and low-speed-enable cases.

// File: rtl/osc_sup_pkg.sv
`timescale 1ns/1ps
package osc_sup_pkg;
  typedef enum logic [1:0] {
    SRC_OTHER = 2'b00,
    SRC_INT16 = 2'b01,
    SRC_EXT   = 2'b10,
    SRC_PLL   = 2'b11
  } sysclk_src_e;
endpackage

// File: rtl/osc_edge_sync.sv
`timescale 1ns/1ps
// Toggle in the monitored domain, synchroniser chain into the reference domain.
module osc_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic ref_clk,
  input  logic rst,
  input  logic mon_clk,
  output logic edge_seen
);
  localparam int CHAIN = SYNC_STAGES + 1;

  logic             tgl;
  logic [CHAIN-1:0] chain;

  always_ff @(posedge mon_clk) begin
    if (rst) tgl <= 1'b0;
    else     tgl <= ~tgl;
  end

  always_ff @(posedge ref_clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[CHAIN-2:0], tgl};
  end

  assign edge_seen = chain[CHAIN-1] ^ chain[CHAIN-2];

  initial begin
    stages_chk: assert (SYNC_STAGES >= 2);
  end
endmodule

// File: rtl/osc_miss_counter.sv
`timescale 1ns/1ps
// Counts reference cycles without a monitored edge while armed.
module osc_miss_counter #(
  parameter int MISS_LIMIT = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic mon_en,
  input  logic osc_on,
  input  logic osc_ready,
  input  logic edge_seen,
  output logic fail_det
);
  localparam int CNT_W = $clog2(MISS_LIMIT + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(MISS_LIMIT - 1);
  localparam logic [CNT_W-1:0] TOP  = CNT_W'(MISS_LIMIT);

  logic [CNT_W-1:0] gap_cnt;
  logic             tripped;
  logic             armed;

  assign armed    = mon_en & osc_on & osc_ready & ~tripped;
  assign fail_det = armed & ~edge_seen & (gap_cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || !armed || edge_seen) gap_cnt <= '0;
    else                            gap_cnt <= gap_cnt + 1'b1;
  end

  // Latched after a failure; released only when the oscillator is switched off.
  always_ff @(posedge clk) begin
    if (rst)           tripped <= 1'b0;
    else if (!osc_on)  tripped <= 1'b0;
    else if (fail_det) tripped <= 1'b1;
  end

  // R3
  gap_bound_chk: assert property (@(posedge clk) disable iff (rst)
    gap_cnt <= TOP);
  // R4
  armed_only_chk: assert property (@(posedge clk) disable iff (rst)
    fail_det |-> (mon_en && osc_on && osc_ready));
  // R9
  no_retrip_chk: assert property (@(posedge clk) disable iff (rst)
    (fail_det && osc_on) |=> !fail_det);
endmodule

// File: rtl/osc_fail_actions.sv
`timescale 1ns/1ps
// Registered failure responses chosen by the clock-tree configuration.
module osc_fail_actions
  import osc_sup_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       fail_det,
  input  logic [1:0] sysclk_src,
  input  logic       pll_src_ext,
  input  logic       irq_clr,
  output logic       osc_off_req,
  output logic       pll_off_req,
  output logic       force_int16,
  output logic       tmr_break,
  output logic       irq_flag
);
  sysclk_src_e src;
  logic        via_pll;
  logic        on_path;

  assign src     = sysclk_src_e'(sysclk_src);
  assign via_pll = (src == SRC_PLL) & pll_src_ext;
  assign on_path = (src == SRC_EXT) | via_pll;

  always_ff @(posedge clk) begin
    if (rst) begin
      osc_off_req <= 1'b0;
      pll_off_req <= 1'b0;
      force_int16 <= 1'b0;
      tmr_break   <= 1'b0;
    end else begin
      osc_off_req <= fail_det;
      tmr_break   <= fail_det;
      force_int16 <= fail_det & on_path;
      pll_off_req <= fail_det & via_pll;
    end
  end

  // A new failure wins over a clear in the same cycle.
  always_ff @(posedge clk) begin
    if (rst)           irq_flag <= 1'b0;
    else if (fail_det) irq_flag <= 1'b1;
    else if (irq_clr)  irq_flag <= 1'b0;
  end

  // R5
  break_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    tmr_break |=> !tmr_break);
  // R7
  pll_implies_force_chk: assert property (@(posedge clk) disable iff (rst)
    pll_off_req |-> force_int16);
  // R6
  force_with_off_chk: assert property (@(posedge clk) disable iff (rst)
    force_int16 |-> osc_off_req);
  // R8
  irq_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_flag && !irq_clr) |=> irq_flag);
  // R8
  irq_set_chk: assert property (@(posedge clk) disable iff (rst)
    osc_off_req |-> irq_flag);
endmodule

// File: rtl/lse_mon_enable.sv
`timescale 1ns/1ps
// Set-only enable for the low-speed oscillator monitor.
module lse_mon_enable (
  input  logic clk,
  input  logic rst,
  input  logic set_req,
  input  logic rtc_sw_rst,
  input  logic lse_fail,
  output logic active
);
  always_ff @(posedge clk) begin
    if (rst || rtc_sw_rst || lse_fail) active <= 1'b0;
    else if (set_req)                  active <= 1'b1;
  end

  // R10
  lse_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (active && !rtc_sw_rst && !lse_fail) |=> active);
  // R10
  lse_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (rtc_sw_rst || lse_fail) |=> !active);
endmodule

// File: rtl/osc_fail_supervisor.sv
`timescale 1ns/1ps
module osc_fail_supervisor #(
  parameter int MISS_LIMIT  = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       mon_clk,
  input  logic       mon_en,
  input  logic       osc_on,
  input  logic       osc_ready,
  input  logic [1:0] sysclk_src,
  input  logic       pll_src_ext,
  input  logic       irq_clr,
  input  logic       lse_mon_set,
  input  logic       rtc_sw_rst,
  input  logic       lse_fail,
  output logic       osc_off_req,
  output logic       pll_off_req,
  output logic       force_int16,
  output logic       tmr_break,
  output logic       irq_flag,
  output logic       lse_mon_active
);
  logic edge_seen;
  logic fail_det;

  osc_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .ref_clk(clk), .rst(rst), .mon_clk(mon_clk), .edge_seen(edge_seen)
  );

  osc_miss_counter #(.MISS_LIMIT(MISS_LIMIT)) u_cnt (
    .clk(clk), .rst(rst), .mon_en(mon_en), .osc_on(osc_on),
    .osc_ready(osc_ready), .edge_seen(edge_seen), .fail_det(fail_det)
  );

  osc_fail_actions u_act (
    .clk(clk), .rst(rst), .fail_det(fail_det), .sysclk_src(sysclk_src),
    .pll_src_ext(pll_src_ext), .irq_clr(irq_clr),
    .osc_off_req(osc_off_req), .pll_off_req(pll_off_req),
    .force_int16(force_int16), .tmr_break(tmr_break), .irq_flag(irq_flag)
  );

  lse_mon_enable u_lse (
    .clk(clk), .rst(rst), .set_req(lse_mon_set), .rtc_sw_rst(rtc_sw_rst),
    .lse_fail(lse_fail), .active(lse_mon_active)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> !(osc_off_req || irq_flag || lse_mon_active || tmr_break));
endmodule

// File: tb/osc_fail_supervisor_test.sv
`timescale 1ns/1ps
module osc_fail_supervisor_test;
  localparam int N = 6;

  logic clk = 1'b0, mon_clk = 1'b0, mon_run = 1'b0;
  logic rst = 1'b1, mon_en = 1'b0, osc_on = 1'b0, osc_ready = 1'b0;
  logic [1:0] sysclk_src = 2'b00;
  logic pll_src_ext = 1'b0, irq_clr = 1'b0;
  logic lse_mon_set = 1'b0, rtc_sw_rst = 1'b0, lse_fail = 1'b0;
  logic osc_off_req, pll_off_req, force_int16, tmr_break, irq_flag, lse_mon_active;

  int tests = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;
  always #7 if (mon_run) mon_clk = ~mon_clk;

  osc_fail_supervisor #(.MISS_LIMIT(N), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst(rst), .mon_clk(mon_clk), .mon_en(mon_en), .osc_on(osc_on),
    .osc_ready(osc_ready), .sysclk_src(sysclk_src), .pll_src_ext(pll_src_ext),
    .irq_clr(irq_clr), .lse_mon_set(lse_mon_set), .rtc_sw_rst(rtc_sw_rst),
    .lse_fail(lse_fail), .osc_off_req(osc_off_req), .pll_off_req(pll_off_req),
    .force_int16(force_int16), .tmr_break(tmr_break), .irq_flag(irq_flag),
    .lse_mon_active(lse_mon_active)
  );

  // {sysclk_src[1:0], pll_src_ext, expected force_int16, expected pll_off_req}
  localparam logic [4:0] VEC [6] = '{
    5'b10_0_1_0, 5'b10_1_1_0, 5'b11_1_1_1,
    5'b11_0_0_0, 5'b01_1_0_0, 5'b00_1_0_0
  };

  task automatic check(string req, int act, int exp, string what);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  // Steps n cycles and counts osc_off_req pulses seen.
  task automatic watch(int n, output int seen);
    seen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (osc_off_req) seen++;
    end
  endtask

  // Stops the monitored clock and waits for the failure request.
  task automatic stop_and_wait(output int cyc, output logic f, output logic p,
                               output logic b);
    cyc = -1; f = 1'b0; p = 1'b0; b = 1'b0;
    mon_run = 1'b0;
    for (int i = 1; i <= 4 * N + 10; i++) begin
      @(negedge clk);
      if (osc_off_req) begin
        cyc = i; f = force_int16; p = pll_off_req; b = tmr_break;
        break;
      end
    end
  endtask

  initial begin
    int seen, cyc;
    logic f, p, b;

    step(4);
    // R1: reset state
    check("R1", int'(osc_off_req | pll_off_req | force_int16 | tmr_break), 0, "pulses in reset");
    check("R1", int'(irq_flag), 0, "irq in reset");
    check("R1", int'(lse_mon_active), 0, "lse in reset");
    mon_run = 1'b1;
    step(4);
    rst = 1'b0;
    mon_en = 1'b1;

    for (int v = 0; v < 6; v++) begin
      osc_on = 1'b0; irq_clr = 1'b1;
      step(2);
      irq_clr = 1'b0;
      sysclk_src = VEC[v][4:3];
      pll_src_ext = VEC[v][2];
      mon_run = 1'b1;
      osc_on = 1'b1; osc_ready = 1'b1;
      watch(30, seen);
      check("R2", seen, 0, $sformatf("vec%0d no fail while running", v));
      stop_and_wait(cyc, f, p, b);
      check("R3", int'(cyc >= N && cyc <= N + 6), 1,
            $sformatf("vec%0d detect latency %0d", v, cyc));
      check("R5", int'(b), 1, $sformatf("vec%0d break with off req", v));
      check("R6", int'(f), int'(VEC[v][1]), $sformatf("vec%0d force_int16", v));
      check("R7", int'(p), int'(VEC[v][0]), $sformatf("vec%0d pll_off_req", v));
      step(1);
      check("R5", int'(osc_off_req | tmr_break), 0, $sformatf("vec%0d pulse width", v));
      check("R8", int'(irq_flag), 1, $sformatf("vec%0d irq set", v));
    end

    // R9: tripped, clock still stopped and osc_on high: no second failure
    watch(4 * N, seen);
    check("R9", seen, 0, "no retrip while osc_on high");
    // R8: flag held through that whole time, then cleared
    check("R8", int'(irq_flag), 1, "irq sticky");
    irq_clr = 1'b1; step(1); irq_clr = 1'b0; step(1);
    check("R8", int'(irq_flag), 0, "irq cleared");
    // R9: re-arm after osc_on low
    osc_on = 1'b0; step(2); osc_on = 1'b1;
    watch(4 * N, seen);
    check("R9", seen, 1, "re-armed after osc_on low");

    // R4: gating with the clock stopped
    osc_on = 1'b0; step(2);
    mon_en = 1'b0; osc_on = 1'b1; osc_ready = 1'b1;
    watch(4 * N, seen);
    check("R4", seen, 0, "mon_en low");
    mon_en = 1'b1; osc_ready = 1'b0;
    watch(4 * N, seen);
    check("R4", seen, 0, "osc_ready low");
    osc_ready = 1'b1; osc_on = 1'b0;
    watch(4 * N, seen);
    check("R4", seen, 0, "osc_on low");

    // R10: low-speed monitor enable
    lse_mon_set = 1'b1; step(1); lse_mon_set = 1'b0; step(10);
    check("R10", int'(lse_mon_active), 1, "lse held");
    lse_fail = 1'b1; step(1); lse_fail = 1'b0;
    check("R10", int'(lse_mon_active), 0, "lse cleared by failure");
    lse_mon_set = 1'b1; step(1); lse_mon_set = 1'b0;
    rtc_sw_rst = 1'b1; step(1); rtc_sw_rst = 1'b0;
    check("R10", int'(lse_mon_active), 0, "lse cleared by rtc reset");
    lse_mon_set = 1'b1; rtc_sw_rst = 1'b1; step(1);
    lse_mon_set = 1'b0; rtc_sw_rst = 1'b0;
    check("R10", int'(lse_mon_active), 0, "clear wins over set");
    lse_mon_set = 1'b1; step(1); lse_mon_set = 1'b0;
    rst = 1'b1; step(1); rst = 1'b0;
    check("R10", int'(lse_mon_active), 0, "lse cleared by rst");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule